// File: doc/BRIEF.md
# Word-Bus Access Sequencer with Reset Completion

This block connects a processor-side request port to a static RAM array that is 16 bits wide. A request can be a byte, a 16-bit word or a 32-bit long word, for either a read or a write. The block turns each request into one or two word-wide bus cycles on the array port. Each bus cycle holds the array port steady for two system clocks. When the request finishes, the block pulses a done strobe and presents the assembled read data. Byte order is big-endian: the byte at the even address sits in bits 15:8 of an array word.

A byte or an aligned word needs one bus cycle. A long word, or a word at an odd address, needs two. A synchronous reset request can arrive while an access is under way. In that case the block follows fixed rules. A byte or word access always runs to its end. A long word is cut short after its first word only if the reset came during that first word. After any access ends, no new request is taken while the reset request stays high.

Top module: `wbus_seq`

## Requirements
- R1: A byte request or a word request at an even address takes one bus cycle. `done` is high in the second clock after the accepting edge.
- R2: Each bus cycle asserts `mem_en` for exactly two consecutive clocks. `mem_waddr`, `mem_be` and `mem_we` are held stable across both clocks.
- R3: A long-word request (`req_size`=2, or the unused code 3), or a word request at an odd address, takes two bus cycles. `done` is high in the fourth clock after acceptance. A long word ignores address bit 0. It moves bits 31:16 at word address addr>>1 first, then bits 15:0 at the next word address.
- R4: A word at odd address A is split into two bus cycles. The first has byte enables `01` at word A>>1 and carries data bits 15:8. The second has `10` at word (A>>1)+1 and carries bits 7:0. The read result is assembled the same way into bits 15:0.
- R5: A byte request (`req_size`=0) uses enable `10` (bits 15:8) at an even address and `01` (bits 7:0) at an odd one. Read data is zero-extended into `rd_data`. A word read at an even address (`req_size`=1) returns the array word in bits 15:0 and zeros above.
- R6: A byte or word access, including a split odd-address word, completes in full when `sync_rst` rises during it.
- R7: If `sync_rst` is high in any clock of the first bus cycle of a long word, only that first word is transferred. `done` comes after one bus cycle, and `rd_data` holds the first word in bits 31:16 and zeros in bits 15:0.
- R8: If `sync_rst` first rises during the second bus cycle of a long word, both words are transferred and the long word completes normally.
- R9: While `sync_rst` is high and the block is idle, `req_ready` is low, no request is accepted and `mem_en` stays low.
- R10: `done` is high for exactly one clock per request. `rd_data` keeps its value until the next request finishes.
- R11: After `arst_n` is released, the block is idle: `req_ready` is high, `done` and `mem_en` are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| sync_rst | input | 1 | Synchronous reset request, follows the completion rules |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 long word (3 behaves as 2) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-justified for byte and word |
| done | output | 1 | One-clock completion strobe |
| rd_data | output | 32 | Assembled read data, valid from `done` |
| mem_en | output | 1 | Array access strobe |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | ADDR_W-1 | Array word address |
| mem_be | output | 2 | Byte lane enables, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | Array write data |
| mem_rdata | input | 16 | Array read data, registered by the array |

## Verification
The main function is tried with a table of byte, word and long-word writes and reads. It includes even and odd byte addresses, aligned and odd-address words, and long words whose halves overlap earlier byte writes. A mixed lane placement or a swapped half shows up as a wrong read-back value. The latency and `mem_en` count of each entry tell one-cycle accesses from two-cycle ones. Directed cases raise `sync_rst` in the first clock, the second clock and the third clock after acceptance. This tells truncation of a long word apart from the completion of word, byte and second-half accesses. An idle reset case shows that no request is taken.

// File: rtl/wbus_pkg.sv
package wbus_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  localparam int LANE_W = 16;
  localparam int DATA_W = 32;

  // long word, with the unused code treated the same way
  function automatic logic size_is_long(xfer_size_e s);
    return (s == SZ_LONG) || (s == SZ_RSVD);
  endfunction

  // true when the request needs two bus cycles
  function automatic logic needs_two(xfer_size_e s, logic a0);
    return size_is_long(s) || ((s == SZ_WORD) && a0);
  endfunction

  // byte lane enables for one bus cycle; bit 1 = bits 15:8 (even byte)
  function automatic logic [1:0] beat_be(xfer_size_e s, logic a0, logic beat);
    logic [1:0] be;
    case (s)
      SZ_BYTE: be = a0 ? 2'b01 : 2'b10;
      SZ_WORD: be = !a0 ? 2'b11 : (beat ? 2'b10 : 2'b01);
      default: be = 2'b11;
    endcase
    return be;
  endfunction

  // lane-aligned write data for one bus cycle
  function automatic logic [LANE_W-1:0] beat_wdata(xfer_size_e s, logic a0,
                                                   logic beat, logic [DATA_W-1:0] wd);
    logic [LANE_W-1:0] d;
    case (s)
      SZ_BYTE: d = {wd[7:0], wd[7:0]};
      SZ_WORD: d = !a0 ? wd[15:0] : (beat ? {wd[7:0], 8'h00} : {8'h00, wd[15:8]});
      default: d = beat ? wd[15:0] : wd[31:16];
    endcase
    return d;
  endfunction

  // assemble read result from first (d0) and second (d1) bus cycle data
  function automatic logic [DATA_W-1:0] merge_read(xfer_size_e s, logic a0,
                                                   logic [LANE_W-1:0] d0,
                                                   logic [LANE_W-1:0] d1);
    logic [DATA_W-1:0] r;
    case (s)
      SZ_BYTE: r = {24'h0, (a0 ? d0[7:0] : d0[15:8])};
      SZ_WORD: r = !a0 ? {16'h0, d0} : {16'h0, d0[7:0], d1[15:8]};
      default: r = {d0, d1};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wbus_lane_map.sv
module wbus_lane_map
  import wbus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  xfer_size_e           size,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 beat,
  output logic [ADDR_W-2:0]    waddr,
  output logic [1:0]           be,
  output logic [LANE_W-1:0]    lane_wdata
);
  localparam int WA_W = ADDR_W - 1;

  always_comb begin
    waddr      = addr[ADDR_W-1:1] + {{(WA_W-1){1'b0}}, beat};
    be         = beat_be(size, addr[0], beat);
    lane_wdata = beat_wdata(size, addr[0], beat, wdata);
  end
endmodule

// File: rtl/wbus_rd_merge.sv
module wbus_rd_merge
  import wbus_pkg::*;
(
  input  xfer_size_e          size,
  input  logic                a0,
  input  logic                second_beat,
  input  logic [LANE_W-1:0]   first_q,
  input  logic [LANE_W-1:0]   lane_rdata,
  output logic [DATA_W-1:0]   merged
);
  logic [LANE_W-1:0] d0, d1;

  always_comb begin
    // finishing in the first cycle: the live lane is word 0, word 1 absent
    d0     = second_beat ? first_q : lane_rdata;
    d1     = second_beat ? lane_rdata : '0;
    merged = merge_read(size, a0, d0, d1);
  end
endmodule

// File: rtl/wbus_seq_ctrl.sv
module wbus_seq_ctrl
  import wbus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                sync_rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [LANE_W-1:0]   mem_rdata,
  output logic                req_ready,
  output logic                busy,
  output logic                beat,
  output logic                first_clk_w,
  output xfer_size_e          cap_size,
  output logic [ADDR_W-1:0]   cap_addr,
  output logic                cap_write,
  output logic [DATA_W-1:0]   cap_wdata,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data
);
  logic              busy_q, beat_q, phase_q, rst_seen_q, done_q;
  logic [LANE_W-1:0] first_q;
  logic [DATA_W-1:0] rd_q, merged_w;
  xfer_size_e        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  // named internal events
  logic accept_w, end_cycle_w, rst_hit_w, go_second_w, finish_w;

  assign accept_w    = req_valid && !busy_q && !sync_rst;
  assign end_cycle_w = busy_q && phase_q;
  assign rst_hit_w   = rst_seen_q || sync_rst;
  assign go_second_w = end_cycle_w && !beat_q && needs_two(size_q, addr_q[0])
                       && !(size_is_long(size_q) && rst_hit_w);
  assign finish_w    = end_cycle_w && !go_second_w;
  assign first_clk_w = busy_q && !phase_q;

  wbus_rd_merge u_merge (
    .size        (size_q),
    .a0          (addr_q[0]),
    .second_beat (beat_q),
    .first_q     (first_q),
    .lane_rdata  (mem_rdata),
    .merged      (merged_w)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy_q     <= 1'b0;
      beat_q     <= 1'b0;
      phase_q    <= 1'b0;
      rst_seen_q <= 1'b0;
      done_q     <= 1'b0;
      first_q    <= '0;
      rd_q       <= '0;
      size_q     <= SZ_BYTE;
      addr_q     <= '0;
      write_q    <= 1'b0;
      wdata_q    <= '0;
    end else begin
      done_q <= finish_w;
      if (accept_w) begin
        busy_q     <= 1'b1;
        beat_q     <= 1'b0;
        phase_q    <= 1'b0;
        rst_seen_q <= 1'b0;
        size_q     <= xfer_size_e'(req_size);
        addr_q     <= req_addr;
        write_q    <= req_write;
        wdata_q    <= req_wdata;
      end else if (busy_q) begin
        phase_q    <= ~phase_q;
        rst_seen_q <= rst_seen_q | sync_rst;
        if (end_cycle_w && !beat_q) first_q <= mem_rdata;
        if (go_second_w) beat_q <= 1'b1;
        if (finish_w) begin
          busy_q <= 1'b0;
          rd_q   <= merged_w;
        end
      end
    end
  end

  assign req_ready = !busy_q && !sync_rst;
  assign busy      = busy_q;
  assign beat      = beat_q;
  assign cap_size  = size_q;
  assign cap_addr  = addr_q;
  assign cap_write = write_q;
  assign cap_wdata = wdata_q;
  assign done      = done_q;
  assign rd_data   = rd_q;

  // R7: a long word may end after its first cycle only under reset
  a_r7_trunc_needs_reset: assert property (@(posedge clk) disable iff (!arst_n)
    (finish_w && !beat_q && size_is_long(size_q)) |-> rst_hit_w);

  // R6: a split odd-address word always proceeds to its second cycle
  a_r6_split_word_continues: assert property (@(posedge clk) disable iff (!arst_n)
    (end_cycle_w && !beat_q && size_q == SZ_WORD && addr_q[0]) |=> (busy_q && beat_q));

  // R8: once the second cycle has begun it runs to its end
  a_r8_second_cycle_runs: assert property (@(posedge clk) disable iff (!arst_n)
    (busy_q && beat_q && !phase_q) |=> (busy_q && beat_q && phase_q));

  // R9: nothing is taken while the reset request is high
  a_r9_no_accept_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
    (sync_rst && !busy_q) |=> !busy_q);
endmodule

// File: rtl/wbus_seq.sv
module wbus_seq
  import wbus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 sync_rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 done,
  output logic [31:0]          rd_data,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [ADDR_W-2:0]    mem_waddr,
  output logic [1:0]           mem_be,
  output logic [15:0]          mem_wdata,
  input  logic [15:0]          mem_rdata
);
  logic              busy_w, beat_w, first_clk_w, cap_write_w;
  xfer_size_e        cap_size_w;
  logic [ADDR_W-1:0] cap_addr_w;
  logic [31:0]       cap_wdata_w;

  wbus_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .arst_n      (arst_n),
    .sync_rst    (sync_rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_size    (req_size),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mem_rdata   (mem_rdata),
    .req_ready   (req_ready),
    .busy        (busy_w),
    .beat        (beat_w),
    .first_clk_w (first_clk_w),
    .cap_size    (cap_size_w),
    .cap_addr    (cap_addr_w),
    .cap_write   (cap_write_w),
    .cap_wdata   (cap_wdata_w),
    .done        (done),
    .rd_data     (rd_data)
  );

  wbus_lane_map #(.ADDR_W(ADDR_W)) u_lanes (
    .size       (cap_size_w),
    .addr       (cap_addr_w),
    .wdata      (cap_wdata_w),
    .beat       (beat_w),
    .waddr      (mem_waddr),
    .be         (mem_be),
    .lane_wdata (mem_wdata)
  );

  assign mem_en = busy_w;
  assign mem_we = busy_w && cap_write_w;

  // R2: the array port is held for both clocks of a bus cycle
  a_r2_cycle_two_clocks: assert property (@(posedge clk) disable iff (!arst_n)
    (mem_en && first_clk_w) |=> (mem_en && $stable(mem_waddr) && $stable(mem_be)
                                 && $stable(mem_we)));

  // R10: the completion strobe lasts one clock
  a_r10_done_single: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> !done);

  // R10: the result is held between completions
  a_r10_rd_held: assert property (@(posedge clk) disable iff (!arst_n)
    !done |-> $stable(rd_data));

  // R9: no request accepted while the reset request is high
  a_r9_ready_low: assert property (@(posedge clk) disable iff (!arst_n)
    sync_rst |-> !req_ready);
endmodule

// File: tb/wbus_seq_tb_top.sv
`timescale 1ns/1ps
module wbus_seq_tb_top;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        sync_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rd_data;
  logic        mem_en, mem_we;
  logic [AW-2:0] mem_waddr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  logic [15:0] mem [0:(1<<(AW-1))-1];

  int n_vec = 0;
  int n_bad = 0;
  int en_cnt = 0;

  always #10 clk = ~clk;

  wbus_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .arst_n(arst_n), .sync_rst(sync_rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // array model: registered read, byte-lane write
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem[mem_waddr];
      if (mem_we) begin
        if (mem_be[1]) mem[mem_waddr][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) mem[mem_waddr][7:0]  <= mem_wdata[7:0];
      end
    end
  end

  always @(negedge clk) if (mem_en) en_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // one request; sync_rst raised at the k-th negedge after acceptance (0 = never)
  task automatic run_req(input logic wr, input logic [1:0] sz, input logic [AW-1:0] ad,
                         input logic [31:0] wd, input int rst_at,
                         output logic [31:0] rd, output int lat);
    rd = '0;
    lat = -1;
    en_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad; req_wdata = wd;
    @(posedge clk);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (done && lat < 0) begin
        lat = k - 1;
        rd = rd_data;
      end
      if (rst_at == k) sync_rst = 1'b1;
      if (lat >= 0) break;
    end
  endtask

  // vector: {write, size, addr, wdata, expected read, latency}
  localparam int NV = 13;
  localparam logic [95:0] VEC [NV] = '{
    {4'h1, 4'h2, 16'h0010, 32'h11223344, 32'h00000000, 8'd4},  // R3 long write
    {4'h0, 4'h2, 16'h0010, 32'h0,        32'h11223344, 8'd4},  // R3 long read
    {4'h1, 4'h1, 16'h0020, 32'h0000ABCD, 32'h00000000, 8'd2},  // R1 word write
    {4'h0, 4'h1, 16'h0020, 32'h0,        32'h0000ABCD, 8'd2},  // R1 R5 word read
    {4'h0, 4'h0, 16'h0021, 32'h0,        32'h000000CD, 8'd2},  // R5 odd byte
    {4'h0, 4'h0, 16'h0020, 32'h0,        32'h000000AB, 8'd2},  // R5 even byte
    {4'h1, 4'h0, 16'h0011, 32'h000000EE, 32'h00000000, 8'd2},  // R5 byte write
    {4'h0, 4'h2, 16'h0010, 32'h0,        32'h11EE3344, 8'd4},  // R5 R3 merge
    {4'h1, 4'h1, 16'h0031, 32'h0000BEEF, 32'h00000000, 8'd4},  // R4 split write
    {4'h0, 4'h1, 16'h0031, 32'h0,        32'h0000BEEF, 8'd4},  // R4 split read
    {4'h0, 4'h2, 16'h0030, 32'h0,        32'h00BEEF00, 8'd4},  // R4 lanes
    {4'h0, 4'h1, 16'h0032, 32'h0,        32'h0000EF00, 8'd2},  // R4 second lane
    {4'h0, 4'h1, 16'h0011, 32'h0,        32'h0000EE33, 8'd4}   // R4 across words
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (R10 completion never seen) actual=hung expected=finished");
    report();
  end

  initial begin
    logic [31:0] rd;
    int lat;
    for (int i = 0; i < (1 << (AW-1)); i++) mem[i] = 16'h0;

    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk) arst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready", {31'h0, req_ready}, 32'h1);
    chk("R11 done", {31'h0, done}, 32'h0);
    chk("R11 mem_en", {31'h0, mem_en}, 32'h0);
    chk("R11 rd_data", rd_data, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [95:0] v;
      v = VEC[i];
      run_req(v[92], v[89:88], v[AW+71:72], v[71:40], 0, rd, lat);
      chk($sformatf("R1/R3 latency vec%0d", i), lat, {24'h0, v[7:0]});
      chk($sformatf("R2 mem_en clocks vec%0d", i), en_cnt, {24'h0, v[7:0]});
      if (!v[92]) chk($sformatf("R4/R5 read vec%0d", i), rd, v[39:8]);
      @(negedge clk);
      chk($sformatf("R10 done one clock vec%0d", i), {31'h0, done}, 32'h0);
      chk($sformatf("R10 rd held vec%0d", i), rd_data, v[92] ? rd_data : v[39:8]);
    end

    // R9: idle with reset request high
    @(negedge clk);
    sync_rst = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd0; req_addr = 10'h020;
    #1;
    chk("R9 ready low", {31'h0, req_ready}, 32'h0);
    en_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R9 no access", en_cnt, 0);
    chk("R9 no done", {31'h0, done}, 32'h0);
    req_valid = 1'b0;
    sync_rst = 1'b0;
    #1;
    chk("R9 ready back", {31'h0, req_ready}, 32'h1);

    // R7: reset in first cycle of a long write
    run_req(1'b1, 2'd2, 10'h040, 32'hCAFEF00D, 1, rd, lat);
    chk("R7 truncated latency", lat, 2);
    chk("R9 ready low after", {31'h0, req_ready}, 32'h0);
    en_cnt = 0;
    repeat (2) @(negedge clk);
    chk("R9 held idle", en_cnt, 0);
    sync_rst = 1'b0;
    run_req(1'b0, 2'd2, 10'h040, 32'h0, 0, rd, lat);
    chk("R7 only first word written", rd, 32'hCAFE0000);

    // R7: reset raised in second clock of first cycle of a long read
    run_req(1'b0, 2'd2, 10'h010, 32'h0, 2, rd, lat);
    chk("R7 read latency", lat, 2);
    chk("R7 read upper only", rd, 32'h11EE0000);
    @(negedge clk) sync_rst = 1'b0;

    // R8: reset during second cycle of a long write
    run_req(1'b1, 2'd2, 10'h050, 32'h12345678, 3, rd, lat);
    chk("R8 full latency", lat, 4);
    @(negedge clk) sync_rst = 1'b0;
    run_req(1'b0, 2'd2, 10'h050, 32'h0, 0, rd, lat);
    chk("R8 both words written", rd, 32'h12345678);

    // R6: reset during split word write and during byte read
    run_req(1'b1, 2'd1, 10'h061, 32'h0000A1B2, 1, rd, lat);
    chk("R6 split word latency", lat, 4);
    @(negedge clk) sync_rst = 1'b0;
    run_req(1'b0, 2'd1, 10'h061, 32'h0, 0, rd, lat);
    chk("R6 split word complete", rd, 32'h0000A1B2);
    run_req(1'b0, 2'd0, 10'h021, 32'h0, 1, rd, lat);
    chk("R6 byte latency", lat, 2);
    chk("R6 byte data", rd, 32'h000000CD);
    @(negedge clk) sync_rst = 1'b0;

    // R3: unused size code acts as long word
    run_req(1'b0, 2'd3, 10'h050, 32'h0, 0, rd, lat);
    chk("R3 code 3 latency", lat, 4);
    chk("R3 code 3 data", rd, 32'h12345678);

    report();
  end
endmodule